// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block picks one interrupt line to service from a parameterised set of request lines. Every line owns an eight-bit priority byte. Only the upper nibble of that byte is kept, so there are sixteen levels, and a smaller value means a more urgent request. A control word sets a split point. The split divides each stored nibble into a group part and a subpriority part. That control word only changes when the write carries a fixed sixteen-bit key.

Each cycle the arbiter looks at the pending vector and registers three results: the winning line, a valid flag, and a preempt-request flag. Pending requests are ranked by group, then by subpriority, then by line index. Preemption uses only the group part. A request preempts the running handler only when its group is strictly more urgent than the group of the active priority. When no handler runs, any winner requests preemption. Software reaches the priority bytes and the control word through a simple word-addressed bus.

Top module: `prio_irq_arbiter`

## Requirements
- R1: Each line has an 8-bit priority byte. Bits [7:4] are stored. Bits [3:0] read as zero, and writes to them are discarded.
- R2: After synchronous reset, every priority byte and the control word read as zero, and win_valid, win_idx and preempt_req are zero.
- R3: A write to the control word updates the split field (bits [10:8]) only when bits [31:16] of the write data equal 0x05FA. Any other control write leaves the field unchanged. The key bits always read back as zero.
- R4: For an effective split value s, the group part is priority bits [7:s+1]. A stored split below 4 acts as 4 and still reads back as stored. A split of 7 leaves no group bits, so all groups are equal.
- R5: Among pending lines, the winner has the lowest stored priority value. Because the group bits sit above the subpriority bits, this means the lowest group first and then the lowest subpriority.
- R6: When pending lines share the same priority value, the lowest line index wins.
- R7: win_valid is set exactly when any pending bit was set at the previous clock edge. All outputs are registered and reflect the inputs and register contents one cycle earlier.
- R8: When act_idle is high, preempt_req follows win_valid.
- R9: When act_idle is low, preempt_req is set only if the winner's group is numerically lower than the group of act_prio[7:4]. A winner in the same group with a better subpriority does not preempt.
- R10: Word address 0 is the control word, and address 1+i is the priority byte of line i (in data bits [7:0]). Writes to any other address change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | NUM_LINES | Pending request per line |
| act_idle | input | 1 | High when no handler is active |
| act_prio | input | 8 | Priority byte of the active handler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| win_idx | output | IDX_W | Index of the winning line |
| win_valid | output | 1 | A winner exists |
| preempt_req | output | 1 | The winner should preempt the active handler |

## Verification
The bench builds the arbiter with NUM_LINES = 6 and ADDR_W = 8. Six lines is not a power of two, so the selection tree runs with padded, never-valid leaves. With so few lines, one pattern can hold equal-priority ties, every split value from 0 to 7, and an address just past the last line. A small set of priority bytes is enough to reach same-group/different-subpriority cases under several split settings. The default of 32 lines is covered only by elaboration.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int          STORE_W   = 4;
    localparam logic [15:0] CTRL_KEY  = 16'h05FA;
    localparam int          SPLIT_MIN = 4;

    typedef struct packed {
        logic               valid;
        logic [STORE_W-1:0] prio;
    } cand_t;

    typedef struct packed {
        logic valid;
        logic preempt;
    } arb_flags_t;

    // Mask over the stored nibble that keeps only the group bits.
    function automatic logic [STORE_W-1:0] group_mask(input logic [2:0] split);
        logic [2:0] eff;
        eff = (int'(split) < SPLIT_MIN) ? 3'(SPLIT_MIN) : split;
        return 4'hF << (eff - 3'd3);
    endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [31:0]                       wdata,
    output logic [31:0]                       rdata,
    output logic [NUM_LINES-1:0][STORE_W-1:0] prio_o,
    output logic [2:0]                        split_o
);

    logic [2:0] split_q;
    logic       ctrl_hit;

    assign ctrl_hit = (addr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            split_q <= '0;
        end else if (wr_en && ctrl_hit && wdata[31:16] == CTRL_KEY) begin
            split_q <= wdata[10:8];
        end
    end

    assign split_o = split_q;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [STORE_W-1:0] cell_q;
        logic               hit;
        assign hit = (addr == ADDR_W'(l + 1));
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (wr_en && hit) begin
                cell_q <= wdata[7:4];
            end
        end
        assign prio_o[l] = cell_q;
    end

    always_comb begin
        rdata = '0;
        if (ctrl_hit) begin
            rdata[10:8] = split_q;
        end else begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (addr == ADDR_W'(l + 1)) rdata[7:4] = prio_o[l];
            end
        end
    end

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl_hit && wdata[31:16] != CTRL_KEY) |=> $stable(split_q)); // R3

    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(prio_o)); // R10

endmodule

// File: rtl/irq_win_tree.sv
module irq_win_tree
    import irq_arb_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_LINES-1:0]              pend,
    input  logic [NUM_LINES-1:0][STORE_W-1:0] prio,
    output logic                              w_valid,
    output logic [IDX_W-1:0]                  w_idx,
    output logic [STORE_W-1:0]                w_prio
);

    localparam int LEVELS = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    cand_t            node_c [NODES];
    logic [IDX_W-1:0] node_i [NODES];

    always_comb begin
        for (int i = 0; i < LEAVES; i++) begin
            if (i < NUM_LINES) begin
                node_c[LEAVES-1+i] = '{valid: pend[i], prio: prio[i]};
            end else begin
                node_c[LEAVES-1+i] = '{valid: 1'b0, prio: '1};
            end
            node_i[LEAVES-1+i] = IDX_W'(i);
        end
        // The left child always holds lower indices, so ties stay left.
        for (int n = LEAVES - 2; n >= 0; n--) begin
            if (node_c[2*n+2].valid &&
                (!node_c[2*n+1].valid || node_c[2*n+2].prio < node_c[2*n+1].prio)) begin
                node_c[n] = node_c[2*n+2];
                node_i[n] = node_i[2*n+2];
            end else begin
                node_c[n] = node_c[2*n+1];
                node_i[n] = node_i[2*n+1];
            end
        end
    end

    assign w_valid = node_c[0].valid;
    assign w_prio  = node_c[0].prio;
    assign w_idx   = node_i[0];

    always_comb begin
        AST_WIN_IS_PENDING: assert (!w_valid || pend[w_idx]); // R5
    end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_pend,
    input  logic                 act_idle,
    input  logic [7:0]           act_prio,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [IDX_W-1:0]     win_idx,
    output logic                 win_valid,
    output logic                 preempt_req
);

    logic [NUM_LINES-1:0][STORE_W-1:0] prio;
    logic [2:0]                        split;
    logic                              c_valid;
    logic [IDX_W-1:0]                  c_idx;
    logic [STORE_W-1:0]                c_prio;
    logic [STORE_W-1:0]                gmask;
    arb_flags_t                        flags_d, flags_q;
    logic [IDX_W-1:0]                  idx_q;

    irq_prio_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .prio_o (prio),
        .split_o(split)
    );

    irq_win_tree #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_tree (
        .pend   (irq_pend),
        .prio   (prio),
        .w_valid(c_valid),
        .w_idx  (c_idx),
        .w_prio (c_prio)
    );

    assign gmask = group_mask(split);

    always_comb begin
        flags_d.valid   = c_valid;
        flags_d.preempt = c_valid &&
                          (act_idle || ((c_prio & gmask) < (act_prio[7:4] & gmask)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            idx_q   <= '0;
        end else begin
            flags_q <= flags_d;
            idx_q   <= c_valid ? c_idx : '0;
        end
    end

    assign win_valid   = flags_q.valid;
    assign preempt_req = flags_q.preempt;
    assign win_idx     = idx_q;

    AST_PREEMPT_NEEDS_WIN: assert property (@(posedge clk) disable iff (rst)
        preempt_req |-> win_valid); // R9

    AST_VALID_TRACKS_PEND: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (win_valid == $past(|irq_pend))); // R7

    AST_IDLE_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(act_idle) && win_valid) |-> preempt_req); // R8

endmodule

// File: tb/test_prio_irq_arbiter.sv
module test_prio_irq_arbiter;

    localparam int N  = 6;
    localparam int AW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_pend = '0;
    logic          act_idle = 1'b1;
    logic [7:0]    act_prio = '0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [IW-1:0] win_idx;
    logic          win_valid;
    logic          preempt_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [3:0] m_prio [N];
    logic [2:0] m_split = '0;

    typedef struct {
        int         due;
        logic       valid;
        logic [2:0] idx;
        logic       pre;
        string      tag;
    } exp_t;

    exp_t sb [$];

    prio_irq_arbiter #(.NUM_LINES(N), .ADDR_W(AW)) i_prio_irq_arbiter (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .act_idle(act_idle),
        .act_prio(act_prio), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .win_idx(win_idx),
        .win_valid(win_valid), .preempt_req(preempt_req)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare scoreboard entries that fall due this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check32({e.tag, " valid/idx/preempt"},
                    {29'd0, win_valid, win_idx} | {28'd0, preempt_req, 3'd0} << 1,
                    {29'd0, e.valid, e.idx} | {28'd0, e.pre, 3'd0} << 1);
        end
    end

    function automatic void model(input logic [N-1:0] p, input logic idle,
                                  input logic [7:0] act, output exp_t e);
        int best;
        int sh;
        e.valid = 1'b0; e.idx = '0; e.pre = 1'b0;
        best = 16;
        for (int i = 0; i < N; i++) begin
            if (p[i] && int'(m_prio[i]) < best) begin
                best = int'(m_prio[i]);
                e.idx = 3'(i);
                e.valid = 1'b1;
            end
        end
        sh = (int'(m_split) < 4) ? 1 : int'(m_split) - 3;
        if (e.valid) e.pre = idle || ((best >> sh) < (int'(act[7:4]) >> sh));
    endfunction

    // Driver: apply one input pattern and push the outcome expected next cycle.
    task automatic step(input logic [N-1:0] p, input logic idle,
                        input logic [7:0] act, input string tag);
        exp_t e;
        @(negedge clk);
        irq_pend = p; act_idle = idle; act_prio = act;
        model(p, idle, act, e);
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check32(tag, bus_rdata, exp);
    endtask

    task automatic set_prio(input int line, input logic [7:0] v);
        bus_write(AW'(line + 1), {24'd0, v});
        m_prio[line] = v[7:4];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_prio[i] = '0;
        irq_pend = 6'b111111;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        irq_pend = '0;
        #1;
        // R2: reset state
        check32("R2 outputs after reset", {30'd0, win_valid, preempt_req}, 32'd0);
        check32("R2 index after reset", {29'd0, win_idx}, 32'd0);
        bus_read(0, 32'd0, "R2 control reset");
        for (int i = 0; i < N; i++) bus_read(AW'(i + 1), 32'd0, "R2 priority reset");

        // R1: low nibble dropped
        set_prio(0, 8'h6B);
        bus_read(1, 32'h60, "R1 low nibble reads zero");
        set_prio(1, 8'h4F); set_prio(2, 8'h40); set_prio(3, 8'h55);
        set_prio(4, 8'hF0); set_prio(5, 8'h21);

        // R10: out-of-range address
        bus_write(AW'(N + 1), 32'hFFFF_FFFF);
        bus_read(AW'(N + 1), 32'd0, "R10 out-of-range read");
        for (int i = 0; i < N; i++) bus_read(AW'(i + 1), {24'd0, m_prio[i], 4'd0}, "R10 lines untouched");

        // R3: keyed control write
        bus_write(0, 32'h1234_0500);
        bus_read(0, 32'd0, "R3 unkeyed write ignored");
        bus_write(0, 32'h05FB_0600);
        bus_read(0, 32'd0, "R3 near-key write ignored");

        // Arbitration with split 0 (acts as 4)
        step(6'b000000, 1'b1, 8'h00, "R7 nothing pending");
        step(6'b000110, 1'b1, 8'h00, "R6 tie lowest index");
        step(6'b001001, 1'b0, 8'hF0, "R5 lowest value wins");
        step(6'b010000, 1'b1, 8'h00, "R8 idle preempts");
        step(6'b000010, 1'b0, 8'h50, "R9 same group no preempt");
        step(6'b100010, 1'b0, 8'h50, "R9 better group preempts");
        step(6'b000010, 1'b0, 8'h40, "R9 equal priority no preempt");
        step(6'b111111, 1'b0, 8'h00, "R9 never beats level 0");
        step(6'b011110, 1'b0, 8'hF0, "R5 lowest among many");

        // R4: split values
        bus_write(0, 32'h05FA_0500); m_split = 3'd5;
        bus_read(0, 32'h0000_0500, "R3 keyed write, key reads zero");
        step(6'b000010, 1'b0, 8'h70, "R4 split5 same group");
        step(6'b100000, 1'b0, 8'h70, "R4 split5 better group");
        bus_write(0, 32'h05FA_0700); m_split = 3'd7;
        step(6'b100000, 1'b0, 8'hF0, "R4 split7 no group bits");
        step(6'b100000, 1'b1, 8'hF0, "R8 split7 idle still preempts");
        bus_write(0, 32'h05FA_0200); m_split = 3'd2;
        bus_read(0, 32'h0000_0200, "R4 small split reads back");
        step(6'b000010, 1'b0, 8'h70, "R4 small split acts as 4");
        step(6'b001000, 1'b0, 8'h40, "R4 small split same group");
        bus_write(0, 32'h05FA_0600); m_split = 3'd6;
        step(6'b001100, 1'b0, 8'h90, "R4 split6 preempt");
        step(6'b001100, 1'b0, 8'h70, "R4 split6 same group");

        // R7: consecutive patterns, one-cycle latency each
        for (int k = 0; k < 16; k++) begin
            step(6'((k * 13) % 64), k[0], 8'((k * 37) % 256), "R7 back-to-back");
        end
        step(6'b000000, 1'b1, 8'h00, "R7 drain");
        repeat (3) @(negedge clk);
        check32("R7 scoreboard drained", sb.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule